// File: doc/BRIEF.md
# Banked Memory Region Decoder

This block classifies every CPU access on a 24-bit address bus. The result is one of five targets: main RAM, auxiliary RAM, ROM, peripheral I/O, or "pass", which means the address is not decoded here. For each access it also produces a 17-bit RAM address, a ROM address, an I/O strobe, a write-inhibit flag, and separate read and write enables. All of these are registered and appear one clock after the access is presented.

Three writable registers steer the mapping.

- **Switch register.** Holds per-range main/auxiliary selects, one for reads and one for writes. It also holds one select that covers the zero page and the stack page.
- **Card register.** Holds four enables, each of which lets a slice of the `$C100`–`$CFFF` peripheral-card space read from ROM instead of I/O.
- **Shadow register.** Holds an inhibit bit. When set, the `$Cxxx` page group in banks `$00` and `$01` becomes ordinary RAM. The mirrors in banks `$E0`/`$E1` keep card decoding.

Auxiliary memory is the bank `$01` copy of a bank `$00` location. The translated RAM address therefore carries the bank choice in its top bit.

Top module: `bank_region_decoder`

## Requirements
- R1: After reset all three registers are zero. `out_valid_o` is 0 while reset is held. With zeroed registers every bank `$00` RAM range maps to main RAM, and every `$Cxxx` page in banks `$00`, `$01`, `$E0` and `$E1` maps to I/O.
- R2: In bank `$00`, pages `$02`–`$03`, `$08`–`$1F` and `$40`–`$BF` use switch bit 0 for reads and switch bit 1 for writes. A set bit gives target auxiliary (code 2) with `ram_addr_o = {1, addr[15:0]}`. A clear bit gives target main (code 1) with `ram_addr_o = {0, addr[15:0]}`.
- R3: In bank `$00`, pages `$04`–`$07` use switch bits 2 (read) and 3 (write). Pages `$20`–`$3F` use switch bits 4 (read) and 5 (write).
- R4: In bank `$00`, pages `$00`–`$01` use switch bit 6 for both reads and writes.
- R5: When card decoding applies, page `$C0` is always I/O (code 4) with `io_o = 1`.
- R6: When card decoding applies, each card slice reads ROM (code 3) if its enable is set and I/O otherwise. The slices and their card-register bits are:
  - `$C1`–`$C2`: bit 0
  - `$C3`: bit 1
  - `$C4`–`$C7`: bit 2
  - `$C8`–`$CF`: bit 3

  For a ROM target, `rom_addr_o = {ROM_BANK, addr[15:0]}` whatever bank was addressed. `rom_addr_o` is zero for every other target, and `ram_addr_o` is zero unless the target is main or auxiliary.
- R7: When card decoding applies, a write to pages `$C1`–`$CF` sets `wr_inhibit_o` and keeps `wr_en_o` low, whether the slice maps to ROM or to I/O.
- R8: With shadow bit 6 set, pages `$C0`–`$CF` of bank `$00` follow switch bits 0/1 as in R2, and those of bank `$01` map to auxiliary RAM. In both banks there is no I/O and no write inhibit.
- R9: Banks `$E0`/`$E1` pages `$C0`–`$CF` apply card decoding regardless of the shadow bit.
- R10: Bank `$01` below `$C000` is always auxiliary RAM. Every address not covered above has target pass (code 0) with no enables.
- R11: A register write is captured on a clock edge and governs accesses from the next cycle on. An access presented in the same cycle as a register write is decoded with the old setting. Results appear one cycle after `acc_valid_i`.
- R12: `cfg_sel_i` selects the register to write:
  - 0: switch register
  - 1: card register, bits 3:0
  - 2: shadow register, bit 6

  A write with select 3 changes nothing.
- R13: `rd_en_o` is high for a read whose target is not pass. `wr_en_o` is high only for a write whose target is main or auxiliary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select (0 switch, 1 card, 2 shadow) |
| cfg_data_i | input | 8 | Register write data |
| acc_valid_i | input | 1 | Access present |
| acc_we_i | input | 1 | Access is a write |
| acc_addr_i | input | 24 | Access address |
| out_valid_o | output | 1 | Decode result valid |
| tgt_o | output | 3 | Target code (0 pass, 1 main, 2 aux, 3 ROM, 4 I/O) |
| ram_addr_o | output | 17 | Translated RAM address, bit 16 selects bank `$01` |
| rom_addr_o | output | 24 | ROM address in the top ROM bank |
| io_o | output | 1 | I/O strobe |
| wr_inhibit_o | output | 1 | Write to a protected card slice |
| rd_en_o | output | 1 | Read enable |
| wr_en_o | output | 1 | Write enable |

## Verification
A register write and a decoded access can occupy the same clock cycle. In that cycle the access must be judged against the setting that held before the edge, not the incoming one. The bench provokes this by driving a switch, card or shadow write together with an access whose mapping the write would change. The reference model computes the expected result from its old register copy before updating that copy. A follow-up access to the same address then confirms that the new setting took hold.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  typedef enum logic [2:0] {
    TGT_PASS = 3'd0,
    TGT_MAIN = 3'd1,
    TGT_AUX  = 3'd2,
    TGT_ROM  = 3'd3,
    TGT_IO   = 3'd4
  } tgt_e;

  typedef struct packed {
    logic zp;
    logic hi_wr;
    logic hi_rd;
    logic txt_wr;
    logic txt_rd;
    logic base_wr;
    logic base_rd;
  } sw_t;

  localparam logic [1:0] CFG_SW     = 2'd0;
  localparam logic [1:0] CFG_CARD   = 2'd1;
  localparam logic [1:0] CFG_SHADOW = 2'd2;

  localparam int unsigned NUM_CARD = 4;
  localparam logic [7:0] CARD_LO [NUM_CARD] = '{8'hC1, 8'hC3, 8'hC4, 8'hC8};
  localparam logic [7:0] CARD_HI [NUM_CARD] = '{8'hC2, 8'hC3, 8'hC7, 8'hCF};
endpackage

// File: rtl/bank_dec_regs.sv
module bank_dec_regs
  import bank_dec_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned INH_BIT = 6,
  parameter int unsigned CARD_N  = NUM_CARD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output sw_t               sw_o,
  output logic [CARD_N-1:0] rom_en_o,
  output logic              inhibit_o
);
  localparam int unsigned SW_W = $bits(sw_t);

  sw_t               sw_q;
  logic [CARD_N-1:0] rom_q;
  logic              inh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      rom_q <= '0;
      inh_q <= 1'b0;
    end else if (cfg_we_i) begin
      unique case (cfg_sel_i)
        CFG_SW:     sw_q  <= sw_t'(cfg_data_i[SW_W-1:0]);
        CFG_CARD:   rom_q <= cfg_data_i[CARD_N-1:0];
        CFG_SHADOW: inh_q <= cfg_data_i[INH_BIT];
        default: ;
      endcase
    end
  end

  assign sw_o      = sw_q;
  assign rom_en_o  = rom_q;
  assign inhibit_o = inh_q;

  a_r12_sw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_sel_i == CFG_SW) |=> $stable(sw_q));
  a_r12_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_sel_i == CFG_SHADOW) |=> $stable(inh_q));
endmodule

// File: rtl/bank_dec_lowmap.sv
module bank_dec_lowmap
  import bank_dec_pkg::*;
(
  input  logic [7:0] page_i,
  input  logic       we_i,
  input  sw_t        sw_i,
  output logic       aux_o
);
  // Bank $00 main/aux choice; pages $C0-$CF fall to the base pair (shadow-inhibit case).
  always_comb begin
    if (page_i <= 8'h01)
      aux_o = sw_i.zp;
    else if (page_i >= 8'h04 && page_i <= 8'h07)
      aux_o = we_i ? sw_i.txt_wr : sw_i.txt_rd;
    else if (page_i >= 8'h20 && page_i <= 8'h3F)
      aux_o = we_i ? sw_i.hi_wr : sw_i.hi_rd;
    else
      aux_o = we_i ? sw_i.base_wr : sw_i.base_rd;
  end
endmodule

// File: rtl/bank_dec_card.sv
module bank_dec_card
  import bank_dec_pkg::*;
#(
  parameter int unsigned CARD_N = NUM_CARD
) (
  input  logic [7:0]        page_i,
  input  logic [CARD_N-1:0] rom_en_i,
  output logic              rom_o,
  output logic              inhibit_o
);
  logic [CARD_N-1:0] hit;

  for (genvar i = 0; i < CARD_N; i++) begin : g_slice
    assign hit[i] = (page_i >= CARD_LO[i]) && (page_i <= CARD_HI[i]);
  end

  assign rom_o     = |(hit & rom_en_i);
  assign inhibit_o = |hit;

  always_comb begin
    a_r6_one_slice: assert ($onehot0(hit));
  end
endmodule

// File: rtl/bank_region_decoder.sv
module bank_region_decoder
  import bank_dec_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned INH_BIT  = 6,
  parameter logic [7:0]  ROM_BANK = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              out_valid_o,
  output logic [2:0]        tgt_o,
  output logic [16:0]       ram_addr_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              io_o,
  output logic              wr_inhibit_o,
  output logic              rd_en_o,
  output logic              wr_en_o
);
  localparam int unsigned OFF_W = 16;
  localparam int unsigned BANK_W = ADDR_W - OFF_W;

  sw_t               sw;
  logic [NUM_CARD-1:0] rom_en;
  logic              shadow_inh;

  bank_dec_regs #(.DATA_W(DATA_W), .INH_BIT(INH_BIT), .CARD_N(NUM_CARD)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .sw_o(sw), .rom_en_o(rom_en), .inhibit_o(shadow_inh)
  );

  logic [BANK_W-1:0] bank;
  logic [7:0]        page;
  logic              b0, b1, be, in_cx;
  logic              low_aux, card_rom, card_inh;

  assign bank  = acc_addr_i[ADDR_W-1:OFF_W];
  assign page  = acc_addr_i[OFF_W-1:8];
  assign b0    = (bank == BANK_W'(8'h00));
  assign b1    = (bank == BANK_W'(8'h01));
  assign be    = (bank == BANK_W'(8'hE0)) || (bank == BANK_W'(8'hE1));
  assign in_cx = (page[7:4] == 4'hC);

  bank_dec_lowmap u_low (.page_i(page), .we_i(acc_we_i), .sw_i(sw), .aux_o(low_aux));
  bank_dec_card #(.CARD_N(NUM_CARD)) u_card (
    .page_i(page), .rom_en_i(rom_en), .rom_o(card_rom), .inhibit_o(card_inh)
  );

  tgt_e tgt_d;
  logic inh_d;

  always_comb begin
    tgt_d = TGT_PASS;
    inh_d = 1'b0;
    if ((b0 || b1) && (page < 8'hC0 || (in_cx && shadow_inh))) begin
      tgt_d = (b1 || low_aux) ? TGT_AUX : TGT_MAIN;
    end else if ((b0 || b1 || be) && in_cx) begin
      tgt_d = card_rom ? TGT_ROM : TGT_IO;
      inh_d = card_inh;
    end
  end

  logic is_ram;
  assign is_ram = (tgt_d == TGT_MAIN) || (tgt_d == TGT_AUX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      tgt_o        <= TGT_PASS;
      ram_addr_o   <= '0;
      rom_addr_o   <= '0;
      io_o         <= 1'b0;
      wr_inhibit_o <= 1'b0;
      rd_en_o      <= 1'b0;
      wr_en_o      <= 1'b0;
    end else begin
      out_valid_o  <= acc_valid_i;
      tgt_o        <= acc_valid_i ? tgt_d : TGT_PASS;
      ram_addr_o   <= (acc_valid_i && is_ram) ? {tgt_d == TGT_AUX, acc_addr_i[OFF_W-1:0]} : '0;
      rom_addr_o   <= (acc_valid_i && tgt_d == TGT_ROM)
                      ? {BANK_W'(ROM_BANK), acc_addr_i[OFF_W-1:0]} : '0;
      io_o         <= acc_valid_i && (tgt_d == TGT_IO);
      wr_inhibit_o <= acc_valid_i && acc_we_i && inh_d;
      rd_en_o      <= acc_valid_i && !acc_we_i && (tgt_d != TGT_PASS);
      wr_en_o      <= acc_valid_i && acc_we_i && is_ram;
    end
  end

  a_r11_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> out_valid_o);
  a_r10_bank1_aux: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && b1 && page < 8'hC0) |=> (tgt_o == TGT_AUX) && ram_addr_o[16]);
  a_r5_c0_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && be && page == 8'hC0) |=> io_o);
  a_r7_card_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_we_i && be && in_cx && page != 8'hC0) |=> wr_inhibit_o && !wr_en_o);
  a_r8_no_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && b0 && in_cx && shadow_inh) |=> !io_o && !wr_inhibit_o);
endmodule

// File: tb/bank_region_decoder_tb_top.sv
module bank_region_decoder_tb_top;
  import bank_dec_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [7:0]  cfg_data_i = '0;
  logic        acc_valid_i = 1'b0;
  logic        acc_we_i = 1'b0;
  logic [23:0] acc_addr_i = '0;
  logic        out_valid_o;
  logic [2:0]  tgt_o;
  logic [16:0] ram_addr_o;
  logic [23:0] rom_addr_o;
  logic        io_o, wr_inhibit_o, rd_en_o, wr_en_o;

  always #10 clk_i = ~clk_i;

  bank_region_decoder dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .acc_valid_i, .acc_we_i, .acc_addr_i,
    .out_valid_o, .tgt_o, .ram_addr_o, .rom_addr_o,
    .io_o, .wr_inhibit_o, .rd_en_o, .wr_en_o
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];

  logic [6:0] m_sw = '0;
  logic [3:0] m_rom = '0;
  logic       m_sh = 1'b0;

  function automatic logic [47:0] ref_map(logic we, logic [23:0] a);
    logic [7:0] bank = a[23:16];
    logic [7:0] page = a[15:8];
    logic lowb = (bank == 8'h00) || (bank == 8'h01);
    logic eb = (bank == 8'hE0) || (bank == 8'hE1);
    logic cx = (page >= 8'hC0) && (page <= 8'hCF);
    logic sel, en;
    logic [2:0] t = 3'd0;
    logic inh = 1'b0;
    if (page <= 8'h01) sel = m_sw[6];
    else if (page >= 8'h04 && page <= 8'h07) sel = we ? m_sw[3] : m_sw[2];
    else if (page >= 8'h20 && page <= 8'h3F) sel = we ? m_sw[5] : m_sw[4];
    else sel = we ? m_sw[1] : m_sw[0];
    if (lowb && (page < 8'hC0 || (cx && m_sh))) begin
      t = (bank == 8'h01 || sel) ? 3'd2 : 3'd1;
    end else if ((lowb || eb) && cx) begin
      if (page == 8'hC0) t = 3'd4;
      else begin
        inh = 1'b1;
        if (page <= 8'hC2) en = m_rom[0];
        else if (page == 8'hC3) en = m_rom[1];
        else if (page <= 8'hC7) en = m_rom[2];
        else en = m_rom[3];
        t = en ? 3'd3 : 3'd4;
      end
    end
    return {t,
            (t == 3'd1 || t == 3'd2) ? {t == 3'd2, a[15:0]} : 17'd0,
            (t == 3'd3) ? {8'hFF, a[15:0]} : 24'd0,
            t == 3'd4, we && inh, !we && t != 3'd0, we && (t == 3'd1 || t == 3'd2)};
  endfunction

  function automatic string req_of(logic we, logic [23:0] a);
    logic [7:0] bank = a[23:16];
    logic [7:0] page = a[15:8];
    logic cx = (page >= 8'hC0) && (page <= 8'hCF);
    if ((bank == 8'h00 || bank == 8'h01) && cx && m_sh) return "R8";
    if ((bank == 8'hE0 || bank == 8'hE1) && cx && m_sh) return "R9";
    if ((bank <= 8'h01 || bank == 8'hE0 || bank == 8'hE1) && cx) begin
      if (page == 8'hC0) return "R5";
      if (we) return "R7";
      return "R6";
    end
    if (bank == 8'h00 && page <= 8'h01) return "R4";
    if (bank == 8'h00 && ((page >= 8'h04 && page <= 8'h07) || (page >= 8'h20 && page <= 8'h3F))) return "R3";
    if (bank == 8'h00 && page < 8'hC0) return we ? "R13" : "R2";
    return "R10";
  endfunction

  task automatic model_cfg(logic [1:0] sel, logic [7:0] d);
    case (sel)
      2'd0: m_sw = d[6:0];
      2'd1: m_rom = d[3:0];
      2'd2: m_sh = d[6];
      default: ;
    endcase
  endtask

  task automatic access(logic we, logic [23:0] a, string tag);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    acc_valid_i = 1'b1; acc_we_i = we; acc_addr_i = a;
    exp_q.push_back(ref_map(we, a));
    tag_q.push_back(tag == "" ? req_of(we, a) : tag);
  endtask

  task automatic cfg(logic [1:0] sel, logic [7:0] d);
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
    model_cfg(sel, d);
  endtask

  // Register write and access in the same cycle: old setting governs the access.
  task automatic collide(logic [1:0] sel, logic [7:0] d, logic we, logic [23:0] a);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
    acc_valid_i = 1'b1; acc_we_i = we; acc_addr_i = a;
    exp_q.push_back(ref_map(we, a));
    tag_q.push_back("R11");
    model_cfg(sel, d);
    access(we, a, "R11");
  endtask

  task automatic idle();
    @(negedge clk_i);
    cfg_we_i = 1'b0; acc_valid_i = 1'b0;
  endtask

  // Monitor: pop and compare as results emerge.
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && out_valid_o) begin
      logic [47:0] act;
      act = {tgt_o, ram_addr_o, rom_addr_o, io_o, wr_inhibit_o, rd_en_o, wr_en_o};
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected result act=%h exp=none", act);
      end else begin
        logic [47:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s addr? act=%h exp=%h", tg, act, e);
        end
      end
    end
  end

  localparam logic [23:0] ADDRS [26] = '{
    24'h000000, 24'h0001FF, 24'h000200, 24'h0003FF, 24'h000400, 24'h0007FF,
    24'h000800, 24'h001FFF, 24'h002000, 24'h003FFF, 24'h004000, 24'h00BFFF,
    24'h00C000, 24'h00C180, 24'h00C3FF, 24'h00C500, 24'h00CFFF, 24'h01C200,
    24'h011234, 24'hE0C080, 24'hE1C3FF, 24'hE0C900, 24'hE0D000, 24'h00D000,
    24'h02C100, 24'hE02000};

  task automatic finish_run();
    repeat (3) idle();
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11 pending results act=%0d exp=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_checks++;
    if (out_valid_o !== 1'b0 || tgt_o !== 3'd0) begin
      n_fail++;
      $display("FAIL R1 reset outputs act=%b/%0d exp=0/0", out_valid_o, tgt_o);
    end
    rst_ni = 1'b1;
    // R1: defaults give main RAM and card I/O
    access(1'b0, 24'h000400, "R1");
    access(1'b1, 24'h004000, "R1");
    access(1'b0, 24'h00C100, "R1");
    access(1'b0, 24'h01C800, "R1");
    access(1'b0, 24'hE1C400, "R1");
    // R12: select 3 writes nothing
    cfg(2'd3, 8'hFF);
    model_cfg(2'd3, 8'hFF);
    access(1'b0, 24'h000000, "R12");
    access(1'b0, 24'h00C100, "R12");
    access(1'b0, 24'h00C000, "R12");
    // R11: collisions for each register
    collide(2'd0, 8'h01, 1'b0, 24'h004000);
    collide(2'd1, 8'h08, 1'b0, 24'hE0C800);
    collide(2'd2, 8'h40, 1'b0, 24'h00C000);
    collide(2'd2, 8'h00, 1'b1, 24'h01C300);
    // Sweep every switch setting under shadow on/off
    for (int s = 0; s < 128; s++) begin
      for (int h = 0; h < 2; h++) begin
        cfg(2'd0, 8'(s));
        cfg(2'd1, 8'(s[3:0] ^ (h ? 4'hA : 4'h5) ^ s[6:3]));
        cfg(2'd2, h ? 8'h40 : 8'hBF);
        for (int i = 0; i < 26; i++) begin
          access(1'b0, ADDRS[i], "");
          access(1'b1, ADDRS[i], "");
        end
      end
    end
    finish_run();
  end
endmodule